// File: doc/BRIEF.md
# Serial Command Front End for a Four-Channel Output Driver

This block is the serial slave port of a four-channel low-side output driver. A host selects the block by pulling an active-low select line low, clocks a command word in on the serial data input (clock idle low, data taken on the rising serial-clock edge, MSB first), and reads a status word back on the serial data output at the same time. The serial pins are asynchronous to the block's system clock. Each one passes through a synchroniser, and all edge detection happens in the system clock domain. For this to work, the system clock must run at least eight times faster than the serial clock.

When the select line goes low, the four per-channel fault flags are loaded into the low nibble of an 8-bit shift register, and the upper nibble is loaded with zeros. Serial data enters at bit 0, and the output bit is taken from bit 7. Because of this, a 16-bit frame returns the status byte followed by the first command byte, which lets the host verify the command or chain several devices. When the select line goes high, the low nibble of the shift register becomes the new channel command. Each channel enable request is the OR of its command bit and its direct-control input, so a channel can still be pulse-width modulated from a pin. A one-cycle strobe marks every committed frame; the fault logic uses it to clear latched faults.

Top module: `outdrv_spi`

## Requirements
- R1: After reset the command register is zero, so `ch_en` equals `par_on`. `spi_sdo_oe` and `frame_done` are low.
- R2: Data on `spi_sdi` is taken on each rising `spi_sclk` edge, MSB first. When `spi_cs_n` rises, bit i of the last eight bits received (bit 0 = last bit) becomes the command for channel i, for i = 0..3.
- R3: The four bits of the last eight received that sit above bit 3 have no effect on any channel.
- R4: The first eight bits shifted out after `spi_cs_n` falls are 0,0,0,0 followed by `flt[3]`, `flt[2]`, `flt[1]`, `flt[0]`. These are the flag values when the fall was detected, so a flag that changes later in the frame is not reported.
- R5: `spi_sdo` changes only on a falling `spi_sclk` edge or on the select fall. In a 16-bit frame, bits 9 to 16 on `spi_sdo` repeat the first eight bits received on `spi_sdi`.
- R6: `spi_sdo_oe` is high only while the block is selected, and it is low in the cycle the frame is committed.
- R7: `ch_en[i]` is the OR of command bit i and `par_on[i]` at all times.
- R8: `frame_done` is high for exactly one system clock per `spi_cs_n` rise. The new command is visible on `ch_en` in that same cycle.
- R9: `spi_sclk` and `spi_sdi` activity while `spi_cs_n` is high leaves the shift register and the command unchanged, and it raises no `frame_done`.
- R10: `frame_done` rises on the third rising `clk_i` edge after `spi_cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data in |
| par_on | input | 4 | Direct per-channel on requests |
| flt | input | 4 | Per-channel fault flags, 1 = fault |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Output enable for the serial data out pad |
| ch_en | output | 4 | Per-channel enable requests |
| frame_done | output | 1 | One-cycle strobe on frame commit |

## Verification
The hardest case to reach from the ports is the 16-bit frame in which the fault flags change after selection. In that frame the second byte on the output must be the echoed first command byte and not a second snapshot of the faults. The stimulus selects the block, changes `flt`, and clocks two bytes. It then compares all sixteen returned bits with a status byte built from the old flags followed by the first byte sent. A behavioural model in the bench delays the pins through a history queue and checks every cycle, so any change to the latency or to the edge handling is visible on the outputs.

// File: rtl/drvspi_pkg.sv
package drvspi_pkg;
  // Serial-pin events seen in the system clock domain
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic clk_rise;
    logic clk_fall;
    logic sel;
    logic data;
  } spi_evt_t;
endpackage

// File: rtl/drvspi_sync.sv
module drvspi_sync #(
  parameter int STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 sdi,
  output drvspi_pkg::spi_evt_t evt
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE = 3'b001; // select idles high

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic [NSIG-1:0] prev_q;

  assign raw = {sdi, sclk, cs_n};

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    always_comb chain_d = {chain_q[STAGES-2:0], raw[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{IDLE[g]}};
      else        chain_q <= chain_d;
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= synced;
  end

  always_comb begin
    evt.cs_fall  = prev_q[0] & ~synced[0];
    evt.cs_rise  = ~prev_q[0] & synced[0];
    evt.clk_rise = ~prev_q[1] & synced[1];
    evt.clk_fall = prev_q[1] & ~synced[1];
    evt.sel      = ~synced[0];
    evt.data     = synced[2];
  end
endmodule

// File: rtl/drvspi_shift.sv
module drvspi_shift #(
  parameter int WIDTH = 8,
  parameter int NCH   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  drvspi_pkg::spi_evt_t evt,
  input  logic [NCH-1:0]       flt,
  output logic [WIDTH-1:0]     sr_q,
  output logic                 sdo_q
);
  logic [WIDTH-1:0] sr_d;
  logic [WIDTH-1:0] fault_word;
  logic             sdo_d;

  always_comb begin
    fault_word           = '0;
    fault_word[NCH-1:0]  = flt;
    sr_d  = sr_q;
    sdo_d = sdo_q;
    if (evt.cs_fall) begin
      sr_d  = fault_word;
      sdo_d = fault_word[WIDTH-1];
    end else if (evt.sel) begin
      if (evt.clk_rise) sr_d  = {sr_q[WIDTH-2:0], evt.data};
      if (evt.clk_fall) sdo_d = sr_q[WIDTH-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      sdo_q <= sdo_d;
    end
  end

  // R9: nothing shifts while deselected
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.sel |=> $stable(sr_q));
  // R5: output bit moves only on a falling serial clock or a select fall
  a_r5_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> ($past(evt.clk_fall) || $past(evt.cs_fall)));
endmodule

// File: rtl/drvspi_cmd.sv
module drvspi_cmd #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic [NCH-1:0] cmd_in,
  input  logic [NCH-1:0] par_on,
  output logic [NCH-1:0] cmd_q,
  output logic [NCH-1:0] ch_en
);
  logic [NCH-1:0] cmd_d;

  always_comb cmd_d = commit ? cmd_in : cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_en[c] = cmd_q[c] | par_on[c];
  end
endmodule

// File: rtl/outdrv_spi.sv
module outdrv_spi #(
  parameter int NCH    = 4,
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           spi_cs_n,
  input  logic           spi_sclk,
  input  logic           spi_sdi,
  input  logic [NCH-1:0] par_on,
  input  logic [NCH-1:0] flt,
  output logic           spi_sdo,
  output logic           spi_sdo_oe,
  output logic [NCH-1:0] ch_en,
  output logic           frame_done
);
  import drvspi_pkg::*;

  logic [1:0]       rst_q;
  logic             rst_n_i;
  spi_evt_t         evt;
  logic [WIDTH-1:0] sr_q;
  logic [NCH-1:0]   cmd_q;
  logic             oe_q, oe_d;
  logic             fd_q, fd_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 2'b00;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_i = rst_q[1];

  drvspi_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk_i), .rst_n(rst_n_i), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .sdi(spi_sdi), .evt(evt)
  );

  drvspi_shift #(.WIDTH(WIDTH), .NCH(NCH)) u_shift (
    .clk(clk_i), .rst_n(rst_n_i), .evt(evt), .flt(flt),
    .sr_q(sr_q), .sdo_q(spi_sdo)
  );

  drvspi_cmd #(.NCH(NCH)) u_cmd (
    .clk(clk_i), .rst_n(rst_n_i), .commit(evt.cs_rise),
    .cmd_in(sr_q[NCH-1:0]), .par_on(par_on), .cmd_q(cmd_q), .ch_en(ch_en)
  );

  always_comb begin
    oe_d = oe_q;
    if (evt.cs_fall)      oe_d = 1'b1;
    else if (evt.cs_rise) oe_d = 1'b0;
    fd_d = evt.cs_rise;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      oe_q <= 1'b0;
      fd_q <= 1'b0;
    end else begin
      oe_q <= oe_d;
      fd_q <= fd_d;
    end
  end

  assign spi_sdo_oe = oe_q;
  assign frame_done = fd_q;

  // R8: strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frame_done |=> !frame_done);
  // R8: command changes only together with the strobe
  a_r8_cmd_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(cmd_q) |-> frame_done);
  // R6: pad released when the frame commits
  a_r6_oe_off_commit: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frame_done |-> !spi_sdo_oe);
  // R4: fault snapshot loaded when selection starts
  a_r4_fault_load: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(spi_sdo_oe) |-> (sr_q[NCH-1:0] == $past(flt)) && (sr_q[WIDTH-1:NCH] == '0));
endmodule

// File: tb/sim_outdrv_spi.sv
module sim_outdrv_spi;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [3:0] par_on = 4'h0, flt = 4'h0;
  logic       sdo, sdo_oe, frame_done;
  logic [3:0] ch_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  outdrv_spi u0 (
    .clk_i(clk), .rst_ni(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
    .spi_sdi(sdi), .par_on(par_on), .flt(flt), .spi_sdo(sdo),
    .spi_sdo_oe(sdo_oe), .ch_en(ch_en), .frame_done(frame_done)
  );

  always #2 clk = ~clk; // 250 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0] hist[$];            // {sdi, sclk, cs_n} samples, newest first
  logic [7:0] m_sr;
  logic       m_sdo, m_oe, m_fd;
  logic [3:0] m_cmd;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {3'b001, 3'b001, 3'b001, 3'b001};
      m_sr = 8'h00; m_sdo = 1'b0; m_oe = 1'b0; m_fd = 1'b0; m_cmd = 4'h0;
    end else begin
      logic [2:0] nw, od;
      hist.push_front({sdi, sclk, cs_n});
      nw = hist[2];
      od = hist[3];
      void'(hist.pop_back());
      m_fd = 1'b0;
      if (od[0] && !nw[0]) begin
        m_sr = {4'h0, flt}; m_sdo = 1'b0; m_oe = 1'b1;
      end else if (!od[0] && nw[0]) begin
        m_cmd = m_sr[3:0]; m_fd = 1'b1; m_oe = 1'b0;
      end else if (!nw[0]) begin
        if (!od[1] && nw[1]) m_sr = {m_sr[6:0], nw[2]};
        if (od[1] && !nw[1]) m_sdo = m_sr[7];
      end
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (rst_n && !done) begin
      chk("R6 oe", sdo_oe, m_oe);
      if (m_oe) chk("R5 sdo", sdo, m_sdo);
      chk("R7 ch_en", ch_en, m_cmd | par_on);
      chk("R8 frame_done", frame_done, m_fd);
    end
  end

  // ---------------- stimulus ----------------
  int lat;

  task automatic xfer(input logic [15:0] word, input int nbits, input logic [3:0] flt_late,
                      output logic [15:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (5) @(negedge clk);
    flt = flt_late;                      // change after the snapshot
    repeat (5) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = word[i];
      repeat (8) @(negedge clk);
      rx[i] = sdo;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    lat = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      #1;
      if (frame_done && lat == 0) lat = k;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] rx;
    int fd_seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    chk("R1 reset ch_en", ch_en, 4'h0);
    chk("R1 reset oe", sdo_oe, 1'b0);
    chk("R1 reset frame_done", frame_done, 1'b0);

    // R2/R3/R4: 8-bit frame, upper nibble set, faults 0110
    flt = 4'b0110;
    xfer(16'h00A5, 8, 4'b0110, rx);
    chk("R4 fault word", rx[7:0], 8'h06);
    chk("R10 latency", lat, 3);
    chk("R2/R3 command", ch_en, 4'h5);

    // R3: only upper bits set
    xfer(16'h00F0, 8, 4'b0110, rx);
    chk("R3 upper ignored", ch_en, 4'h0);

    // R7: direct inputs ORed with command
    xfer(16'h0003, 8, 4'b0000, rx);
    @(negedge clk) par_on = 4'b1000;
    @(negedge clk); #1;
    chk("R7 or", ch_en, 4'b1011);
    @(negedge clk) par_on = 4'b0000;

    // R4/R5: 16-bit frame, faults change after selection
    @(negedge clk) flt = 4'b1001;
    repeat (2) @(negedge clk);
    xfer(16'h3C9A, 16, 4'b0100, rx);
    chk("R4 snapshot", rx[15:8], 8'h09);
    chk("R5 echo", rx[7:0], 8'h3C);
    chk("R2 16-bit command", ch_en, 4'hA);

    // R9: serial activity while deselected
    fd_seen = 0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk) sdi = j[0];
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      #1;
      if (frame_done) fd_seen++;
    end
    repeat (6) @(negedge clk);
    #1;
    chk("R9 command held", ch_en, 4'hA);
    chk("R9 no strobe", fd_seen, 0);
    chk("R9 oe low", sdo_oe, 1'b0);

    // R4/R2: a fresh frame still reports the current faults
    flt = 4'b1111;
    xfer(16'h0006, 8, 4'b1111, rx);
    chk("R4 all faults", rx[7:0], 8'h0F);
    chk("R2 command 6", ch_en, 4'h6);
    chk("R10 latency again", lat, 3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule